// File: doc/BRIEF.md
# PLL Phase-Step Response Meter

This block measures how an integer-N PLL recovers from a phase disturbance that the chip creates itself. When a measurement is started, the controller changes the feedback divider count for exactly one feedback period. The count is lengthened or shortened by a programmable number of VCO cycles, and this shifts the feedback phase by that amount. No outside signal generator is needed. From then on, the controller reads the phase detector's early/late decision once per reference cycle and turns the loop's transient into a few numbers.

The first number is the crossover time: the count of reference cycles from the step until the error first reverses polarity. It stands in for the closed-loop bandwidth, because a shorter crossover means a wider loop. The second is the length of the overcorrection lobe that follows crossover, and it stands in for jitter peaking. The block then watches the loop settle. It declares lock, and it records the net early/late balance over the lock window as a residual static phase error. Measurements whose settings are illegal, or that never reach crossover, are refused or abandoned with a flag.

The phase detector decisions arrive as one sample per reference cycle, with no handshake. The block always takes the sample, so it cannot back-pressure the loop. All control and result pins are plain levels, except the start request and the one-cycle completion strobe.

Top module: `pll_step_meas`

## Requirements
- R1: After reset, busy, done, step_now, locked, err_div and err_timeout are 0, and all three result fields read 0. While idle, div_count equals fb_div zero-extended.
- R2: A start pulse while idle with fb_div below 8 is refused. err_div becomes 1, busy stays 0, no step is applied, and the previous results stay unchanged.
- R3: An accepted start sets busy. Two cycles later, div_count carries fb_div+step_size (step_dir=1) or fb_div-step_size (step_dir=0) for exactly one cycle, and step_now is high only in that cycle. Settings are captured when the start is accepted.
- R4: Sample 1 is the detector sample in the cycle after the step cycle. pd_late=1 with pd_early=0 is a late sample and counts +1. pd_early=1 with pd_late=0 is an early sample and counts -1. Any other pair is neutral. A reversed sample is early when step_dir=1 and late when step_dir=0. cross_cycles equals the index of the first reversed sample.
- R5: max_overshoot equals the number of consecutive reversed samples starting at the crossover sample, saturating at 4095. A larger step gives a longer lobe, and the crossover barely moves.
- R6: The sample that ends the lobe is not watched. From the next sample on, a settle cycle is good when the current run of equal non-neutral samples is at most 2 long; neutral samples end a run. Sixty-four good settle samples in a row complete the measurement with locked=1. done is then seen in the cycle after the 64th of those samples.
- R7: On completion, static_err (signed, 8 bits) holds the sum of the +1/-1 sample values over the good settle samples since the last bad one. For a lock this is the 64-sample window.
- R8: If 4095 samples pass without a reversed one, err_timeout becomes 1 and busy falls without a done pulse.
- R9: If lock is not reached within 4095 settle samples, the measurement completes with locked=0. static_err is 0 when the last of those samples was bad.
- R10: done is a single-cycle pulse, after which busy is 0. Results and flags do not change until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Measurement request, sampled while idle |
| fb_div | input | 6 | Programmed feedback divide value |
| step_size | input | 3 | Phase step in VCO cycles |
| step_dir | input | 1 | 1 lengthens the step period, 0 shortens it |
| pd_early | input | 1 | Detector says feedback is early |
| pd_late | input | 1 | Detector says feedback is late |
| div_count | output | 7 | Count the feedback divider uses this period |
| step_now | output | 1 | High in the cycle the step is applied |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | One-cycle completion strobe |
| cross_cycles | output | 12 | Crossover time in reference cycles |
| max_overshoot | output | 12 | Overcorrection lobe length |
| static_err | output | 8 | Signed residual error balance |
| locked | output | 1 | Lock reached in the last measurement |
| err_div | output | 1 | Last start refused, divide value too low |
| err_timeout | output | 1 | Last measurement found no crossover |

## Verification
The bench builds the block with its default parameters: a 12-bit counter limit of 4095, a 64-sample lock window and a run limit of 2. At these values the overshoot saturation, the crossover timeout and the settle limit can each be reached directly, within a few thousand cycles. Scripted sample streams set the exact crossover and lobe lengths. A small damped loop model in the bench, with a detector dead zone, reacts to the div_count the block emits, and this shows how the results move as the step size changes.

// File: rtl/pll_meas_pkg.sv
package pll_meas_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ARM    = 3'd1,
    ST_STEP   = 3'd2,
    ST_WAIT   = 3'd3,
    ST_TRACK  = 3'd4,
    ST_SETTLE = 3'd5,
    ST_DONE   = 3'd6
  } meas_state_t;
endpackage

// File: rtl/pll_step_apply.sv
// Chooses the count the feedback divider uses in the current period.
module pll_step_apply #(
  parameter int DIV_W  = 6,
  parameter int STEP_W = 3
) (
  input  logic [DIV_W-1:0]  base_n,
  input  logic [STEP_W-1:0] step_amt,
  input  logic              lengthen,
  input  logic              apply,
  output logic [DIV_W:0]    count
);
  logic [DIV_W:0] wide_n, wide_s;

  always_comb begin
    wide_n = {1'b0, base_n};
    wide_s = (DIV_W+1)'(step_amt);
    if (!apply)        count = wide_n;
    else if (lengthen) count = wide_n + wide_s;
    else               count = wide_n - wide_s;
  end
endmodule

// File: rtl/pll_lock_watch.sv
// Tracks polarity runs during settling and accumulates the signed balance.
module pll_lock_watch #(
  parameter int LOCK_LEN = 64,
  parameter int RUN_MAX  = 2,
  parameter int ACC_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    active,
  input  logic                    s_pos,
  input  logic                    s_neg,
  output logic                    lock_hit,
  output logic signed [ACC_W-1:0] acc_total
);
  localparam int RUN_W = $clog2(RUN_MAX + 2);
  localparam int GC_W  = $clog2(LOCK_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(RUN_MAX + 1);
  localparam logic [GC_W-1:0]  GC_LAST = GC_W'(LOCK_LEN - 1);

  logic                    last_pos;
  logic [RUN_W-1:0]        run_q, run_d;
  logic [GC_W-1:0]         good_q, good_d;
  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic                    good;

  always_comb begin
    if (!s_pos && !s_neg)                 run_d = '0;
    else if (run_q != '0 && last_pos == s_pos)
      run_d = (run_q == RUN_SAT) ? RUN_SAT : run_q + 1'b1;
    else                                  run_d = RUN_W'(1);
    good = (run_d <= RUN_W'(RUN_MAX));
    if (good) begin
      good_d = good_q + 1'b1;
      if (s_pos)      acc_d = acc_q + ACC_W'(1);
      else if (s_neg) acc_d = acc_q - ACC_W'(1);
      else            acc_d = acc_q;
    end else begin
      good_d = '0;
      acc_d  = '0;
    end
    lock_hit  = active && good && (good_q == GC_LAST);
    acc_total = acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_pos <= 1'b0;
      run_q    <= '0;
      good_q   <= '0;
      acc_q    <= '0;
    end else if (clear) begin
      last_pos <= 1'b0;
      run_q    <= '0;
      good_q   <= '0;
      acc_q    <= '0;
    end else if (active) begin
      if (s_pos || s_neg) last_pos <= s_pos;
      run_q  <= run_d;
      good_q <= good_d;
      acc_q  <= acc_d;
    end
  end
endmodule

// File: rtl/pll_meas_ctrl.sv
// Sequencer: arms, steps, times crossover, sizes the lobe, waits for lock.
module pll_meas_ctrl
  import pll_meas_pkg::*;
#(
  parameter int DIV_W        = 6,
  parameter int STEP_W       = 3,
  parameter int CNT_W        = 12,
  parameter int MIN_DIV      = 8,
  parameter int ACC_W        = 8,
  parameter int SETTLE_LIMIT = 4095
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [DIV_W-1:0]        fb_div,
  input  logic [STEP_W-1:0]       step_size,
  input  logic                    step_dir,
  input  logic                    rev,
  input  logic                    lock_hit,
  input  logic signed [ACC_W-1:0] acc_total,
  output meas_state_t             state,
  output logic [DIV_W-1:0]        n_q,
  output logic [STEP_W-1:0]       size_q,
  output logic                    dir_q,
  output logic [CNT_W-1:0]        cross_q,
  output logic [CNT_W-1:0]        over_q,
  output logic signed [ACC_W-1:0] static_q,
  output logic                    locked_q,
  output logic                    err_div_q,
  output logic                    err_tmo_q
);
  localparam logic [CNT_W-1:0] CNT_MAX    = '1;
  localparam logic [CNT_W-1:0] SETTLE_END = CNT_W'(SETTLE_LIMIT);
  localparam logic [DIV_W-1:0] DIV_FLOOR  = DIV_W'(MIN_DIV);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      n_q       <= '0;
      size_q    <= '0;
      dir_q     <= 1'b0;
      cnt       <= '0;
      cross_q   <= '0;
      over_q    <= '0;
      static_q  <= '0;
      locked_q  <= 1'b0;
      err_div_q <= 1'b0;
      err_tmo_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          if (fb_div < DIV_FLOOR) begin
            err_div_q <= 1'b1;
          end else begin
            n_q       <= fb_div;
            size_q    <= step_size;
            dir_q     <= step_dir;
            cross_q   <= '0;
            over_q    <= '0;
            static_q  <= '0;
            locked_q  <= 1'b0;
            err_div_q <= 1'b0;
            err_tmo_q <= 1'b0;
            state     <= ST_ARM;
          end
        end
        ST_ARM:  state <= ST_STEP;
        ST_STEP: begin
          cnt   <= CNT_W'(1);
          state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rev) begin
            cross_q <= cnt;
            over_q  <= CNT_W'(1);
            state   <= ST_TRACK;
          end else if (cnt == CNT_MAX) begin
            err_tmo_q <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TRACK: begin
          if (rev) begin
            if (over_q != CNT_MAX) over_q <= over_q + 1'b1;
          end else begin
            cnt   <= CNT_W'(1);
            state <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (lock_hit) begin
            locked_q <= 1'b1;
            static_q <= acc_total;
            state    <= ST_DONE;
          end else if (cnt == SETTLE_END) begin
            locked_q <= 1'b0;
            static_q <= acc_total;
            state    <= ST_DONE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_step_meas.sv
module pll_step_meas
  import pll_meas_pkg::*;
#(
  parameter int DIV_W        = 6,
  parameter int STEP_W       = 3,
  parameter int CNT_W        = 12,
  parameter int MIN_DIV      = 8,
  parameter int LOCK_LEN     = 64,
  parameter int RUN_MAX      = 2,
  parameter int ACC_W        = 8,
  parameter int SETTLE_LIMIT = 4095
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [DIV_W-1:0]        fb_div,
  input  logic [STEP_W-1:0]       step_size,
  input  logic                    step_dir,
  input  logic                    pd_early,
  input  logic                    pd_late,
  output logic [DIV_W:0]          div_count,
  output logic                    step_now,
  output logic                    busy,
  output logic                    done,
  output logic [CNT_W-1:0]        cross_cycles,
  output logic [CNT_W-1:0]        max_overshoot,
  output logic signed [ACC_W-1:0] static_err,
  output logic                    locked,
  output logic                    err_div,
  output logic                    err_timeout
);
  meas_state_t             state;
  logic [DIV_W-1:0]        n_q;
  logic [STEP_W-1:0]       size_q;
  logic                    dir_q;
  logic                    s_pos, s_neg, rev;
  logic                    lock_hit;
  logic signed [ACC_W-1:0] acc_total;

  assign s_pos    = pd_late & ~pd_early;
  assign s_neg    = pd_early & ~pd_late;
  assign rev      = dir_q ? s_neg : s_pos;
  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_DONE);
  assign step_now = (state == ST_STEP);

  pll_meas_ctrl #(
    .DIV_W(DIV_W), .STEP_W(STEP_W), .CNT_W(CNT_W), .MIN_DIV(MIN_DIV),
    .ACC_W(ACC_W), .SETTLE_LIMIT(SETTLE_LIMIT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .fb_div(fb_div),
    .step_size(step_size), .step_dir(step_dir), .rev(rev),
    .lock_hit(lock_hit), .acc_total(acc_total), .state(state),
    .n_q(n_q), .size_q(size_q), .dir_q(dir_q), .cross_q(cross_cycles),
    .over_q(max_overshoot), .static_q(static_err), .locked_q(locked),
    .err_div_q(err_div), .err_tmo_q(err_timeout)
  );

  pll_step_apply #(.DIV_W(DIV_W), .STEP_W(STEP_W)) u_apply (
    .base_n(busy ? n_q : fb_div), .step_amt(size_q), .lengthen(dir_q),
    .apply(step_now), .count(div_count)
  );

  pll_lock_watch #(.LOCK_LEN(LOCK_LEN), .RUN_MAX(RUN_MAX), .ACC_W(ACC_W)) u_watch (
    .clk(clk), .rst_n(rst_n), .clear(state != ST_SETTLE),
    .active(state == ST_SETTLE), .s_pos(s_pos), .s_neg(s_neg),
    .lock_hit(lock_hit), .acc_total(acc_total)
  );
endmodule

// File: rtl/pll_meas_chk.sv
module pll_meas_chk #(
  parameter int DIV_W   = 6,
  parameter int CNT_W   = 12,
  parameter int MIN_DIV = 8,
  parameter int ACC_W   = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic [DIV_W-1:0]        fb_div,
  input logic [DIV_W:0]          div_count,
  input logic                    step_now,
  input logic                    busy,
  input logic                    done,
  input logic [CNT_W-1:0]        cross_cycles,
  input logic [CNT_W-1:0]        max_overshoot,
  input logic signed [ACC_W-1:0] static_err,
  input logic                    locked,
  input logic                    err_div,
  input logic                    err_timeout
);
  assert_idle_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> div_count == {1'b0, fb_div});

  assert_reject_low_div_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && fb_div < DIV_W'(MIN_DIV)) |=> (!busy && err_div));

  assert_step_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_now |=> !step_now);

  assert_step_moves_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_now |-> busy);

  assert_lock_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> done);

  assert_timeout_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |-> (!busy && !done));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_results_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(cross_cycles) && $stable(max_overshoot) &&
                          $stable(static_err) && $stable(locked)));
endmodule

bind pll_step_meas pll_meas_chk #(
  .DIV_W(DIV_W), .CNT_W(CNT_W), .MIN_DIV(MIN_DIV), .ACC_W(ACC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .fb_div(fb_div),
  .div_count(div_count), .step_now(step_now), .busy(busy), .done(done),
  .cross_cycles(cross_cycles), .max_overshoot(max_overshoot),
  .static_err(static_err), .locked(locked), .err_div(err_div),
  .err_timeout(err_timeout)
);

// File: tb/tb_pll_step_meas.sv
module tb_pll_step_meas;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [5:0] fb_div = 6'd12;
  logic [2:0] step_size = 3'd1;
  logic step_dir = 1'b1;
  logic pd_early = 1'b0, pd_late = 1'b0;
  logic [6:0] div_count;
  logic step_now, busy, done, locked, err_div, err_timeout;
  logic [11:0] cross_cycles, max_overshoot;
  logic signed [7:0] static_err;

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #2ns clk = ~clk;

  pll_step_meas dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fb_div(fb_div),
    .step_size(step_size), .step_dir(step_dir), .pd_early(pd_early),
    .pd_late(pd_late), .div_count(div_count), .step_now(step_now),
    .busy(busy), .done(done), .cross_cycles(cross_cycles),
    .max_overshoot(max_overshoot), .static_err(static_err),
    .locked(locked), .err_div(err_div), .err_timeout(err_timeout)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // {late, early} for sample idx of a scripted response
  function automatic logic [1:0] pat(input int idx, input int c, input int o,
                                     input int mode, input int dir);
    logic [1:0] stp, rvs;
    int j;
    stp = dir ? 2'b10 : 2'b01;
    rvs = dir ? 2'b01 : 2'b10;
    if (idx < c) return stp;
    if (idx < c + o) return rvs;
    if (idx == c + o) return stp;
    j = idx - c - o;
    case (mode)
      0: return (j % 2 == 1) ? rvs : stp;
      1: return (j % 3 == 0) ? 2'b01 : 2'b10;
      2: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  function automatic int exp_static(input int c, input int o, input int mode, input int dir);
    int s = 0;
    for (int j = 1; j <= 64; j++) begin
      logic [1:0] v;
      v = pat(c + o + j, c, o, mode, dir);
      if (v == 2'b10) s++;
      else if (v == 2'b01) s--;
    end
    return s;
  endfunction

  // Run one measurement. use_model drives a damped loop model instead of pat().
  task automatic run_meas(input int n, input int s, input int dir, input int c,
                          input int o, input int mode, input bit use_model,
                          output int end_idx, output bit saw_done,
                          output int step_val, output bit step_once);
    real p, q;
    int idx;
    @(negedge clk);
    fb_div = 6'(n); step_size = 3'(s); step_dir = dir[0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    step_val = -1;
    for (int k = 0; k < 8; k++) begin
      if (step_now) begin step_val = int'(div_count); break; end
      @(negedge clk);
    end
    p = 4.0 * real'(step_val - n); q = 0.0;
    saw_done = 1'b0; step_once = 1'b1; idx = 1; end_idx = 0;
    while (idx < 20000) begin
      @(negedge clk);
      if (idx == 1 && step_now) step_once = 1'b0;
      if (done) begin saw_done = 1'b1; end_idx = idx; break; end
      if (!busy) begin end_idx = idx; break; end
      if (use_model) begin
        pd_late = (p > 0.5); pd_early = (p < -0.5);
        q = q + 0.01 * p;
        p = p - 0.1 * p - q;
      end else begin
        {pd_late, pd_early} = pat(idx, c, o, mode, dir);
      end
      idx++;
    end
    pd_late = 1'b0; pd_early = 1'b0;
  endtask

  // n, step, dir, cross, lobe, settle mode
  localparam int NV = 5;
  localparam int VT [NV][6] = '{
    '{12, 3, 1, 5, 4, 0},
    '{ 8, 1, 0, 2, 1, 0},
    '{63, 7, 1, 9, 6, 1},
    '{20, 5, 0, 1, 12, 1},
    '{30, 2, 1, 4, 3, 3}
  };

  initial begin
    #(4ns * 100000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int e_idx, sv, ca, cb, ma, mb;
    bit sd, once;
    logic [11:0] keep_c, keep_o;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !step_now, "R1", "idle strobes", {busy, done, step_now}, 0);
    chk(!locked && !err_div && !err_timeout, "R1", "flags", {locked, err_div, err_timeout}, 0);
    chk(cross_cycles == 0 && max_overshoot == 0 && static_err == 0, "R1", "results",
        int'(cross_cycles) + int'(max_overshoot), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(div_count == 7'd12, "R1", "idle div_count", int'(div_count), 12);

    for (int v = 0; v < NV; v++) begin
      int n, s, d, c, o, m, exp_step;
      n = VT[v][0]; s = VT[v][1]; d = VT[v][2]; c = VT[v][3]; o = VT[v][4]; m = VT[v][5];
      run_meas(n, s, d, c, o, m, 1'b0, e_idx, sd, sv, once);
      exp_step = d ? n + s : n - s;
      chk(sv == exp_step, "R3", "step count", sv, exp_step);
      chk(once, "R3", "step one cycle", int'(once), 1);
      chk(sd && e_idx == c + o + 65, "R6", "done timing", e_idx, c + o + 65);
      chk(int'(cross_cycles) == c, "R4", "crossover", int'(cross_cycles), c);
      chk(int'(max_overshoot) == o, "R5", "lobe", int'(max_overshoot), o);
      chk(locked, "R6", "locked", int'(locked), 1);
      chk(int'(static_err) == exp_static(c, o, m, d), "R7", "static",
          int'(static_err), exp_static(c, o, m, d));
      @(negedge clk);
      chk(!done && !busy, "R10", "done pulse", {done, busy}, 0);
    end

    // R10 results held while idle; R2 refused start leaves them
    keep_c = cross_cycles; keep_o = max_overshoot;
    repeat (5) @(negedge clk);
    chk(cross_cycles == keep_c && max_overshoot == keep_o, "R10", "hold",
        int'(cross_cycles), int'(keep_c));
    fb_div = 6'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err_div && !busy, "R2", "reject", {err_div, busy}, 2);
    chk(div_count == 7'd7, "R2", "no step", int'(div_count), 7);
    repeat (4) @(negedge clk);
    chk(!busy && cross_cycles == keep_c && max_overshoot == keep_o, "R2", "results kept",
        int'(cross_cycles), int'(keep_c));

    // R5 saturation of the lobe count
    run_meas(16, 2, 1, 3, 4100, 0, 1'b0, e_idx, sd, sv, once);
    chk(!err_div, "R10", "flag cleared", int'(err_div), 0);
    chk(max_overshoot == 12'd4095, "R5", "saturate", int'(max_overshoot), 4095);
    chk(cross_cycles == 12'd3, "R4", "cross sat run", int'(cross_cycles), 3);

    // R9 no lock within settle limit
    run_meas(16, 2, 1, 3, 2, 2, 1'b0, e_idx, sd, sv, once);
    chk(sd && e_idx == 3 + 2 + 4096, "R9", "settle limit", e_idx, 4101);
    chk(!locked && static_err == 0, "R9", "unlocked result", {locked, static_err}, 0);

    // R8 crossover timeout
    run_meas(16, 2, 1, 100000, 1, 0, 1'b0, e_idx, sd, sv, once);
    chk(!sd && e_idx == 4096, "R8", "timeout index", e_idx, 4096);
    chk(err_timeout && !busy, "R8", "timeout flag", {err_timeout, busy}, 2);

    // R5 / R4 with a damped loop model: lobe grows with step, crossover stays put
    run_meas(20, 2, 1, 0, 0, 0, 1'b1, e_idx, sd, sv, once);
    ca = int'(cross_cycles); ma = int'(max_overshoot);
    chk(sd && locked, "R6", "model lock small", int'(locked), 1);
    run_meas(20, 6, 1, 0, 0, 0, 1'b1, e_idx, sd, sv, once);
    cb = int'(cross_cycles); mb = int'(max_overshoot);
    chk(sd && locked, "R6", "model lock large", int'(locked), 1);
    chk(mb > ma, "R5", "lobe scales", mb, ma + 1);
    chk((cb - ca) <= 3 && (ca - cb) <= 3, "R4", "cross steady", cb, ca);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule